// File: doc/BRIEF.md
# Round-Robin Thread Issue Arbiter

This block decides, in every clock cycle, which hardware thread context may place one instruction into a pipeline that all threads share. Each thread presents two inputs. The first says whether the thread exists, meaning it is active. The second says whether it could issue now, meaning it is ready. A thread that is blocked on I/O drops its ready input. Threads that are active, ready and not already holding an instruction in the pipeline compete. The winner is found by rotating priority that starts one position past the thread granted last.

A thread that issues stays ineligible until its instruction has cleared the pipeline. With four pipeline stages, up to four running threads each get exactly one cycle in four, and the remaining cycles are bubbles. With more than four threads, each thread gets one cycle in n. A slot that a blocked thread leaves unused goes to any other eligible thread.

The grant appears in the same cycle as the inputs that produce it. It is presented three ways: as a one-hot vector, as a valid flag and as an encoded thread index. A free-running counter for each thread counts the slots that thread has been granted, so a consumer can measure the share each thread receives.

Top module: `rr_issue_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every in-flight countdown, sets the rotation pointer to thread 0 and zeroes all slot counters. After reset, any thread that is active and ready is eligible at once, and thread 0 has the highest priority.
- R2: `issue_grant` has at most one bit set. `issue_valid` is high exactly when a bit is set.
- R3: A thread is granted only when its bit is set in both `thread_active` and `thread_ready`. A thread that is inactive or not ready is ignored.
- R4: After a thread is granted, that thread is not granted again for the next PIPE_DEPTH-1 cycles.
- R5: The grant goes to the first eligible thread found by scanning upward from the rotation pointer and wrapping at NUM_THREADS-1. After each grant, the pointer moves to the granted index plus one, modulo NUM_THREADS.
- R6: With k ≤ PIPE_DEPTH threads that are always active and ready, each one is granted exactly once in every PIPE_DEPTH cycles. The remaining cycles are bubbles.
- R7: With n > PIPE_DEPTH threads that are always active and ready, each one is granted exactly once in every n cycles, in ascending index order.
- R8: When a thread is not ready, the cycle it would have had goes to the next eligible thread in rotation order. No cycle is left idle while any thread is eligible.
- R9: When no thread is eligible, `issue_valid` is 0 and `issue_grant` is all zeros.
- R10: Field i of `slot_count` (bits i*CNT_W and up) increases by one, with wrap, on the clock edge that ends a cycle in which thread i is granted. Otherwise it holds its value.
- R11: While `issue_valid` is high, `issue_tid` holds the binary index of the set bit in `issue_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thread_active | input | NUM_THREADS | Bit i high: thread i exists |
| thread_ready | input | NUM_THREADS | Bit i high: thread i has an instruction and is not waiting on I/O |
| issue_grant | output | NUM_THREADS | One-hot grant for this cycle (combinational) |
| issue_valid | output | 1 | High when an instruction issues this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Index of the granted thread |
| slot_count | output | NUM_THREADS*CNT_W | Packed per-thread issue-slot counters |

## Verification
The bench builds the arbiter with its defaults: eight threads, a four-stage pipeline, 16-bit counters and the scanning picker. That configuration allows one stretch in which four threads rotate at exactly a quarter share each and another in which two threads leave two bubbles between issues. It also allows a full set of eight threads that rotates at one in eight, and a pointer that wraps past index 7. Stalling one thread inside the eight-thread set shows its slot moving to the next thread. Resets applied mid-run while a countdown is nonzero and while the pointer sits far from 0 show that both return to their starting values.

// File: rtl/rr_issue_pkg.sv
package rr_issue_pkg;

   localparam int unsigned MAX_THREADS = 32;

   typedef logic [MAX_THREADS-1:0] thread_vec_t;

   // Index of the lowest set bit; 0 when the vector is empty.
   function automatic int unsigned lowest_set(input thread_vec_t v);
      int unsigned r;
      r = 0;
      for (int i = MAX_THREADS - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/rr_inflight_tracker.sv
module rr_inflight_tracker #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PIPE_DEPTH  = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_THREADS-1:0] issued,
   output logic [NUM_THREADS-1:0] idle
);
   localparam int unsigned BUSY_W    = $clog2(PIPE_DEPTH);
   localparam int unsigned BUSY_LOAD = PIPE_DEPTH - 1;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
      logic [BUSY_W-1:0] busy;

      always_ff @(posedge clk) begin
         if (rst)
            busy <= '0;
         else if (issued[t])
            busy <= BUSY_W'(BUSY_LOAD);
         else if (busy != '0)
            busy <= busy - 1'b1;
      end

      assign idle[t] = (busy == '0);
   end

endmodule

// File: rtl/rr_rotate_pick.sv
module rr_rotate_pick
   import rr_issue_pkg::*;
#(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PICK_IMPL   = 0,
   localparam int unsigned ID_W       = $clog2(NUM_THREADS)
) (
   input  logic [NUM_THREADS-1:0] req,
   input  logic [ID_W-1:0]        start,
   output logic [NUM_THREADS-1:0] grant,
   output logic                   found,
   output logic [ID_W-1:0]        idx
);

   if (PICK_IMPL == 0) begin : g_scan
      // Walk the ring from the start position and keep the first hit.
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int k = 0; k < int'(NUM_THREADS); k++) begin
            int cand;
            cand = int'(start) + k;
            if (cand >= int'(NUM_THREADS)) cand = cand - int'(NUM_THREADS);
            if (!found && req[cand]) begin
               found = 1'b1;
               idx   = ID_W'(cand);
            end
         end
      end
   end else begin : g_mask
      // Split requests into those at or above start and the rest.
      thread_vec_t upper, whole;
      always_comb begin
         upper = '0;
         whole = '0;
         for (int i = 0; i < int'(NUM_THREADS); i++) begin
            whole[i] = req[i];
            upper[i] = req[i] && (i >= int'(start));
         end
         found = (whole != '0);
         if (upper != '0)
            idx = ID_W'(lowest_set(upper));
         else
            idx = ID_W'(lowest_set(whole));
      end
   end

   assign grant = found ? (NUM_THREADS'(1) << idx) : '0;

endmodule

// File: rtl/rr_slot_counter.sv
module rr_slot_counter #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned CNT_W       = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_THREADS-1:0]       hit,
   output logic [NUM_THREADS*CNT_W-1:0] counts
);

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cnt
      logic [CNT_W-1:0] value;

      always_ff @(posedge clk) begin
         if (rst)
            value <= '0;
         else if (hit[t])
            value <= value + 1'b1;
      end

      assign counts[t*CNT_W +: CNT_W] = value;
   end

endmodule

// File: rtl/rr_issue_arbiter.sv
module rr_issue_arbiter #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PIPE_DEPTH  = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PICK_IMPL   = 0,
   localparam int unsigned ID_W       = $clog2(NUM_THREADS)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_THREADS-1:0]       thread_active,
   input  logic [NUM_THREADS-1:0]       thread_ready,
   output logic [NUM_THREADS-1:0]       issue_grant,
   output logic                         issue_valid,
   output logic [ID_W-1:0]              issue_tid,
   output logic [NUM_THREADS*CNT_W-1:0] slot_count
);

   if (NUM_THREADS < 2 || NUM_THREADS > rr_issue_pkg::MAX_THREADS) begin : g_bad_threads
      $error("rr_issue_arbiter: NUM_THREADS out of range");
   end
   if (PIPE_DEPTH < 2) begin : g_bad_depth
      $error("rr_issue_arbiter: PIPE_DEPTH must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rr_issue_arbiter: CNT_W must be at least 1");
   end
   if (PICK_IMPL > 1) begin : g_bad_impl
      $error("rr_issue_arbiter: PICK_IMPL must be 0 or 1");
   end

   localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_THREADS - 1);

   logic [NUM_THREADS-1:0] idle;
   logic [NUM_THREADS-1:0] eligible;
   logic [ID_W-1:0]        rr_ptr;
   logic                   pick_found;
   logic [ID_W-1:0]        pick_idx;

   assign eligible = thread_active & thread_ready & idle;

   rr_inflight_tracker #(
      .NUM_THREADS(NUM_THREADS),
      .PIPE_DEPTH (PIPE_DEPTH)
   ) u_track (
      .clk   (clk),
      .rst   (rst),
      .issued(issue_grant),
      .idle  (idle)
   );

   rr_rotate_pick #(
      .NUM_THREADS(NUM_THREADS),
      .PICK_IMPL  (PICK_IMPL)
   ) u_pick (
      .req  (eligible),
      .start(rr_ptr),
      .grant(issue_grant),
      .found(pick_found),
      .idx  (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (rst)
         rr_ptr <= '0;
      else if (pick_found)
         rr_ptr <= (pick_idx == LAST_ID) ? '0 : pick_idx + 1'b1;
   end

   rr_slot_counter #(
      .NUM_THREADS(NUM_THREADS),
      .CNT_W      (CNT_W)
   ) u_slots (
      .clk   (clk),
      .rst   (rst),
      .hit   (issue_grant),
      .counts(slot_count)
   );

   assign issue_valid = pick_found;
   assign issue_tid   = pick_idx;

endmodule

// File: rtl/rr_issue_arbiter_chk.sv
module rr_issue_arbiter_chk #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PIPE_DEPTH  = 4,
   parameter int unsigned CNT_W       = 16,
   localparam int unsigned ID_W       = $clog2(NUM_THREADS)
) (
   input logic                         clk,
   input logic                         rst,
   input logic [NUM_THREADS-1:0]       thread_active,
   input logic [NUM_THREADS-1:0]       thread_ready,
   input logic [NUM_THREADS-1:0]       issue_grant,
   input logic                         issue_valid,
   input logic [ID_W-1:0]              issue_tid,
   input logic [NUM_THREADS*CNT_W-1:0] slot_count
);
   localparam int unsigned GAP_W = $clog2(PIPE_DEPTH) + 1;

   logic [NUM_THREADS-1:0] free_seen;

   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(issue_grant));

   a_r2_valid_match: assert property (@(posedge clk) disable iff (rst)
      issue_valid == (issue_grant != '0));

   a_r3_eligible_only: assert property (@(posedge clk) disable iff (rst)
      (issue_grant & ~(thread_active & thread_ready)) == '0);

   a_r11_tid_match: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> (issue_grant == (NUM_THREADS'(1) << issue_tid)));

   // R8: a thread that is active, ready and past its gap means a slot is used
   a_r8_work_conserving: assert property (@(posedge clk) disable iff (rst)
      ((thread_active & thread_ready & free_seen) != '0) |-> issue_valid);

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [GAP_W-1:0] gap;

      always_ff @(posedge clk) begin
         if (rst)
            gap <= '0;
         else if (issue_grant[t])
            gap <= GAP_W'(PIPE_DEPTH - 1);
         else if (gap != '0)
            gap <= gap - 1'b1;
      end

      assign free_seen[t] = (gap == '0);

      a_r4_reissue_gap: assert property (@(posedge clk) disable iff (rst)
         issue_grant[t] |-> (gap == '0));

      a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
         issue_grant[t] |=> (slot_count[t*CNT_W +: CNT_W] ==
                             $past(slot_count[t*CNT_W +: CNT_W]) + 1'b1));

      a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
         !issue_grant[t] |=> $stable(slot_count[t*CNT_W +: CNT_W]));
   end

endmodule

bind rr_issue_arbiter rr_issue_arbiter_chk #(
   .NUM_THREADS(NUM_THREADS),
   .PIPE_DEPTH (PIPE_DEPTH),
   .CNT_W      (CNT_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .thread_active(thread_active),
   .thread_ready (thread_ready),
   .issue_grant  (issue_grant),
   .issue_valid  (issue_valid),
   .issue_tid    (issue_tid),
   .slot_count   (slot_count)
);

// File: tb/rr_issue_arbiter_test.sv
`timescale 1ns/1ps
module rr_issue_arbiter_test;

   localparam int N  = 8;
   localparam int CW = 16;
   localparam int IW = 3;
   localparam int NV = 33;

   // Each entry: {active, ready, expected grant}
   localparam logic [23:0] VEC [0:NV-1] = '{
      24'h0F0F01, 24'h0F0F02, 24'h0F0F04, 24'h0F0F08,
      24'h0F0F01, 24'h0F0F02, 24'h0F0F04, 24'h0F0F08,
      24'h030301, 24'h030302, 24'h030300, 24'h030300,
      24'h030301, 24'h030302, 24'h030300, 24'h030300,
      24'hFFFF04, 24'hFFFF08, 24'hFFFF10, 24'hFFFF20,
      24'hFFFF40, 24'hFFFF80, 24'hFFFF01, 24'hFFFF02,
      24'hFFFF04,
      24'hFFF710, 24'hFFF720, 24'hFFF740, 24'hFFF780,
      24'hFFF701,
      24'hFF0808, 24'hFF0800, 24'h00FF00
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [N-1:0]      thread_active = '0;
   logic [N-1:0]      thread_ready  = '0;
   logic [N-1:0]      issue_grant;
   logic              issue_valid;
   logic [IW-1:0]     issue_tid;
   logic [N*CW-1:0]   slot_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int tally [N];

   always #4 clk = ~clk;

   rr_issue_arbiter #(.NUM_THREADS(N), .PIPE_DEPTH(4), .CNT_W(CW)) uut (
      .clk(clk), .rst(rst),
      .thread_active(thread_active), .thread_ready(thread_ready),
      .issue_grant(issue_grant), .issue_valid(issue_valid),
      .issue_tid(issue_tid), .slot_count(slot_count)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
      @(posedge clk);
      #1;
      thread_active = a;
      thread_ready  = r;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      thread_active = '0;
      thread_ready  = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      for (int t = 0; t < N; t++)
         chk("R1 slot count cleared", 32'(slot_count[t*CW +: CW]), 32'd0);
      @(posedge clk);
      #1;
      rst = 1'b0;
   endtask

   function automatic string tag_of(input int i);
      if (i < 8)       return "R6/R5/R4 four-thread quarter share";
      else if (i < 16) return "R6/R9 two threads with bubbles";
      else if (i < 25) return "R7/R5 eight-thread rotation";
      else if (i < 30) return "R8 stalled thread skipped";
      else             return "R9/R3/R4 no eligible thread";
   endfunction

   function automatic int index_of(input logic [N-1:0] v);
      int r = 0;
      for (int i = 0; i < N; i++) if (v[i]) r = i;
      return r;
   endfunction

   initial begin
      for (int t = 0; t < N; t++) tally[t] = 0;
      do_reset();
      chk("R1 no grant while idle", 32'(issue_grant), 32'd0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [N-1:0] exp_g;
         exp_g = VEC[i][7:0];
         step(VEC[i][23:16], VEC[i][15:8]);
         chk(tag_of(i), 32'(issue_grant), 32'(exp_g));
         chk("R2 valid flag", 32'(issue_valid), 32'(exp_g != '0));
         if (exp_g != '0) begin
            chk("R11 thread index", 32'(issue_tid), 32'(index_of(exp_g)));
            tally[index_of(exp_g)]++;
         end
      end
      step('0, '0);
      for (int t = 0; t < N; t++)
         chk("R10 slot counter", 32'(slot_count[t*CW +: CW]), 32'(tally[t]));

      // R1: reset clears an in-flight countdown
      step(8'h01, 8'h01);
      chk("R1 pre-reset issue", 32'(issue_grant), 32'h01);
      do_reset();
      @(negedge clk);
      thread_active = 8'h01;
      thread_ready  = 8'h01;
      #1;
      chk("R1 countdown cleared", 32'(issue_grant), 32'h01);

      // R1: reset returns the pointer to thread 0
      step(8'h20, 8'h20);
      chk("R1 pre-reset issue thread 5", 32'(issue_grant), 32'h20);
      do_reset();
      @(negedge clk);
      thread_active = 8'hFF;
      thread_ready  = 8'hFF;
      #1;
      chk("R1 pointer at thread 0", 32'(issue_grant), 32'h01);
      chk("R11 thread index after reset", 32'(issue_tid), 32'd0);

      // R3: active but not ready, and ready but not active, are ignored
      step(8'hF0, 8'h0F);
      chk("R3 mismatched masks ignored", 32'(issue_grant), 32'd0);
      chk("R9 valid low", 32'(issue_valid), 32'd0);

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule